// File: doc/BRIEF.md
# Serial Register-Access Slave with Pipelined Read-Back

This block lets an external host read and write a bank of 16-bit control registers over four serial pins. Every transaction is one fixed 24-bit frame, shifted in most significant bit first. The top bit chooses read or write, the next seven bits name a register, and the low sixteen bits carry the data. A write takes effect when chip-select is released. A read does not answer in its own frame. The slave fetches the register when chip-select rises and shifts the value out during the host's next frame.

All serial inputs pass through synchronizers into the system clock domain, where edges are detected. The system clock must run at least four times faster than the serial clock. Chip-select must stay high for at least four system clocks between frames. Logic on the chip reads the same register bank through a parallel port that has one clock of latency. The bank is written so that a block RAM can hold it. A per-entry "written" bit makes every register read as zero after reset.

Top module: `spi_regbank_slave`

## Requirements
- R1: A frame is 24 bits, MSB first, with SDI sampled on each falling SCLK edge while chip-select is low. Bit 23 selects the command (0 = write, 1 = read), bits 22:16 are the register address and bits 15:0 are the data.
- R2: A write frame stores its data in the addressed register on the chip-select rising edge, and only if exactly 24 falling SCLK edges occurred. The stored value is then visible on the parallel port.
- R3: After a committed read frame, the next frame carries the addressed register's value on SDO in bit positions 15:0, MSB first. Positions 23:16 are driven as 0 in every frame.
- R4: In the frame that follows a committed write, SDO data positions 15:0 are driven as 0. The data bits on SDI of a read frame have no effect.
- R5: A frame that ends after any count of falling SCLK edges other than 24 is discarded. No register changes, and the pending read-back value stays in place for the next frame.
- R6: While chip-select is high, SDO is high-impedance, and SCLK and SDI activity has no effect on registers or on pending read-back data.
- R7: After reset every register reads as 0, and the first frame after reset returns 0 in its data positions.
- R8: SDO changes only after rising SCLK edges (bit 23 is presented from the chip-select falling edge), so it is stable at every falling edge.
- R9: The parallel port returns the stored value of the register at `host_addr` one system clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip-select from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host; high-impedance while cs_n is high |
| host_addr | input | 7 | Parallel-port register address |
| host_data | output | 16 | Parallel-port register contents, one clock after host_addr |

## Verification
The hardest state to reach is a pending read-back value that survives frames that do nothing. To get there, the stimulus commits a read and then sends a 23-edge frame, a 25-edge frame and a burst of SCLK and SDI toggling with chip-select high. A full frame follows, and the bench expects the earlier read's value on SDO. The bench also uses the parallel port to confirm that the aborted write frames left their target register unchanged. A mid-run reset followed by two reads checks that both the pending value and the bank contents are cleared.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int DEF_ADDR_W  = 7;
  localparam int DEF_DATA_W  = 16;
  localparam int DEF_SYNC    = 2;

  typedef enum logic {
    CMD_WRITE = 1'b0,
    CMD_READ  = 1'b1
  } cmd_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic cs_high_o,
  output logic sdi_o
);
  // bit 2 = chip-select, bit 1 = serial clock, bit 0 = data
  localparam logic [2:0] IDLE_V = 3'b100;

  logic [2:0] raw;
  logic [2:0] chain [STAGES];
  logic [2:0] cur;
  logic [2:0] last_q;

  assign raw = {cs_n_i, sclk_i, sdi_i};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= IDLE_V;
        else     chain[s] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= IDLE_V;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign cur = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) last_q <= IDLE_V;
    else     last_q <= cur;
  end

  assign sclk_rise_o = cur[1] & ~last_q[1];
  assign sclk_fall_o = ~cur[1] & last_q[1];
  assign cs_fall_o   = ~cur[2] & last_q[2];
  assign cs_rise_o   = cur[2] & ~last_q[2];
  assign cs_high_o   = cur[2];
  assign sdi_o       = cur[0];
endmodule

// File: rtl/spi_rb_bank.sv
module spi_rb_bank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written_q;
  logic [DATA_W-1:0] ma_q, mb_q;
  logic              va_q, vb_q;

  // storage: no reset, so it maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    ma_q <= mem[raddr_a_i];
    mb_q <= mem[raddr_b_i];
  end

  // reset-clearable "written" flags mask stale RAM contents
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      va_q      <= 1'b0;
      vb_q      <= 1'b0;
    end else begin
      if (we_i) written_q[waddr_i] <= 1'b1;
      va_q <= written_q[raddr_a_i];
      vb_q <= written_q[raddr_b_i];
    end
  end

  assign rdata_a_o = va_q ? ma_q : '0;
  assign rdata_b_o = vb_q ? mb_q : '0;

  // R2: a commit is a single-cycle pulse per frame
  p_we_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    we_i |=> !we_i);
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sdo_bit_o,
  output logic              sdo_oe_o
);
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);

  logic               active_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q;
  logic [FRAME_W-1:0] tx_q;
  logic [DATA_W-1:0]  hold_q;
  logic               hold_vld_q;
  logic               rd_req_q;
  logic               rd_cap_q;

  cmd_e              rx_cmd;
  logic [ADDR_W-1:0] rx_addr;
  logic [DATA_W-1:0] rx_data;
  logic              commit;

  assign rx_cmd  = cmd_e'(rx_q[FRAME_W-1]);
  assign rx_addr = rx_q[FRAME_W-2 -: ADDR_W];
  assign rx_data = rx_q[DATA_W-1:0];
  assign commit  = cs_rise_i && active_q && (cnt_q == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      rd_req_q   <= 1'b0;
      rd_cap_q   <= 1'b0;
      rd_addr_o  <= '0;
      we_o       <= 1'b0;
      waddr_o    <= '0;
      wdata_o    <= '0;
    end else begin
      we_o     <= 1'b0;
      rd_req_q <= 1'b0;
      rd_cap_q <= rd_req_q;
      if (rd_cap_q) hold_q <= rd_data_i;

      if (cs_fall_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        tx_q     <= {{(FRAME_W-DATA_W){1'b0}}, (hold_vld_q ? hold_q : {DATA_W{1'b0}})};
      end else if (active_q) begin
        if (sclk_fall_i) begin
          rx_q <= {rx_q[FRAME_W-2:0], sdi_i};
          if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        end
        // the first rising edge precedes any sample; bit 23 stays put
        if (sclk_rise_i && cnt_q != '0) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        if (cs_rise_i) begin
          active_q <= 1'b0;
          if (commit) begin
            if (rx_cmd == CMD_READ) begin
              rd_req_q   <= 1'b1;
              rd_addr_o  <= rx_addr;
              hold_vld_q <= 1'b1;
            end else begin
              we_o       <= 1'b1;
              waddr_o    <= rx_addr;
              wdata_o    <= rx_data;
              hold_vld_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign sdo_bit_o = tx_q[FRAME_W-1];
  assign sdo_oe_o  = active_q;

  // R8: outgoing shift register only moves on SCLK rise or frame start
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(sclk_rise_i || cs_fall_i) |=> $stable(tx_q));
  // R6: a chip-select release closes the frame
  p_frame_close_r6: assert property (@(posedge clk) disable iff (rst)
    cs_rise_i |=> !active_q);
  // R5: edge counter saturates just past a full frame
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_SAT);
  // R3: a read commit arms the read-back for the next frame
  p_read_arms_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req_q |=> hold_vld_q);
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int DATA_W      = DEF_DATA_W,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_data
);
  logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_high, sdi_s;
  logic              bank_we;
  logic [ADDR_W-1:0] bank_waddr, bank_raddr;
  logic [DATA_W-1:0] bank_wdata, bank_rdata;
  logic              sdo_bit, sdo_oe;

  spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .cs_high_o(cs_high), .sdi_o(sdi_s)
  );

  spi_rb_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .sdi_i(sdi_s),
    .rd_data_i(bank_rdata),
    .we_o(bank_we), .waddr_o(bank_waddr), .wdata_o(bank_wdata),
    .rd_addr_o(bank_raddr),
    .sdo_bit_o(sdo_bit), .sdo_oe_o(sdo_oe)
  );

  spi_rb_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst),
    .we_i(bank_we), .waddr_i(bank_waddr), .wdata_i(bank_wdata),
    .raddr_a_i(bank_raddr), .rdata_a_o(bank_rdata),
    .raddr_b_i(host_addr), .rdata_b_o(host_data)
  );

  assign sdo = sdo_oe ? sdo_bit : 1'bz;

  // R2: registers are only written once chip-select is back high
  p_we_cs_idle_r2: assert property (@(posedge clk) disable iff (rst)
    bank_we |-> cs_high);
  // R6: the output driver is off whenever chip-select has been high two cycles
  p_sdo_off_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_high && $past(cs_high)) |-> !sdo_oe);
endmodule

// File: tb/spi_regbank_slave_bench.sv
module spi_regbank_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int NVEC       = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  wire         sdo;
  logic [6:0]  host_addr = '0;
  logic [15:0] host_data;

  int checks = 0;
  int errors = 0;

  spi_regbank_slave u_spi_regbank_slave (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .host_addr(host_addr), .host_data(host_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {cmd, addr[6:0], sdi data[15:0], expected sdo data[15:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b0, 7'h05, 16'hA5A5, 16'h0000},
    {1'b0, 7'h7F, 16'h1234, 16'h0000},
    {1'b1, 7'h05, 16'hDEAD, 16'h0000},
    {1'b1, 7'h7F, 16'hBEEF, 16'hA5A5},
    {1'b1, 7'h00, 16'hFFFF, 16'h1234},
    {1'b0, 7'h05, 16'hFFFF, 16'h0000},
    {1'b1, 7'h05, 16'h0000, 16'h0000},
    {1'b1, 7'h10, 16'h5555, 16'hFFFF},
    {1'b0, 7'h10, 16'h8001, 16'h0000},
    {1'b1, 7'h10, 16'hAAAA, 16'h0000},
    {1'b1, 7'h7F, 16'h0000, 16'h8001},
    {1'b0, 7'h00, 16'h0F0F, 16'h1234}
  };

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one chip-select window with nclk serial clock pulses
  task automatic xfer(input logic [23:0] word, input int nclk, output logic [23:0] got);
    got  = '0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b1;
      sdi  = (i < 24) ? word[23-i] : 1'b0;
      wait_clk(HALF);
      if (i < 24) got[23-i] = sdo;
      sclk = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    sdi  = 1'b0;
    wait_clk(10);
  endtask

  task automatic peek(input logic [6:0] a, output logic [15:0] v);
    host_addr = a;
    wait_clk(2);
    v = host_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] got;
    logic [15:0] pv;

    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);

    // R6/R7: idle state after reset
    check(sdo === 1'bz, "R6 sdo idle high-Z", {23'b0, sdo}, 24'h0);
    peek(7'h05, pv);
    check(pv == 16'h0, "R7 register reset", {8'h0, pv}, 24'h0);

    // table walk: R1 framing, R3 pipelined read, R4 zero after write
    for (int k = 0; k < NVEC; k++) begin
      logic [39:0] v;
      v = VEC[k];
      xfer(v[39:16], 24, got);
      check(got[15:0] == v[15:0], "R1/R3/R4 sdo data field", {8'h0, got[15:0]}, {8'h0, v[15:0]});
      check(got[23:16] == 8'h0, "R3 upper bits zero", {16'h0, got[23:16]}, 24'h0);
      if (v[39] == 1'b0) begin
        peek(v[38:32], pv);
        check(pv == v[31:16], "R2/R9 write visible on parallel port", {8'h0, pv}, {8'h0, v[31:16]});
      end
    end

    // arm a read of 0x7F (holds 0x1234)
    xfer({1'b1, 7'h7F, 16'h0}, 24, got);
    check(got[15:0] == 16'h0, "R4 after write", {8'h0, got[15:0]}, 24'h0);

    // R5: short and long frames are discarded
    xfer({1'b0, 7'h05, 16'h0000}, 23, got);
    peek(7'h05, pv);
    check(pv == 16'hFFFF, "R5 short frame no write", {8'h0, pv}, 24'h00FFFF);
    xfer({1'b0, 7'h05, 16'h0000}, 25, got);
    peek(7'h05, pv);
    check(pv == 16'hFFFF, "R5 long frame no write", {8'h0, pv}, 24'h00FFFF);

    // R6: activity with chip-select high
    for (int i = 0; i < 30; i++) begin
      sclk = ~sclk;
      sdi  = i[1];
      wait_clk(HALF);
      if (i == 15) check(sdo === 1'bz, "R6 sdo high-Z while deselected", {23'b0, sdo}, 24'h0);
    end
    sclk = 1'b0;
    sdi  = 1'b0;
    wait_clk(10);

    // pending read-back survives all of the above (R5, R6); bits stable (R8)
    xfer({1'b0, 7'h10, 16'h0000}, 24, got);
    check(got[15:0] == 16'h1234, "R5/R6/R8 pending read preserved", {8'h0, got[15:0]}, 24'h001234);
    peek(7'h10, pv);
    check(pv == 16'h0000, "R2 overwrite to zero", {8'h0, pv}, 24'h0);
    peek(7'h7F, pv);
    check(pv == 16'h1234, "R9 parallel read other entry", {8'h0, pv}, 24'h001234);

    // R7: reset clears bank and pending read
    xfer({1'b1, 7'h7F, 16'h0}, 24, got);
    rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    wait_clk(3);
    peek(7'h7F, pv);
    check(pv == 16'h0, "R7 bank cleared", {8'h0, pv}, 24'h0);
    xfer({1'b1, 7'h05, 16'h0}, 24, got);
    check(got[15:0] == 16'h0, "R7 no pending read after reset", {8'h0, got[15:0]}, 24'h0);
    xfer({1'b1, 7'h00, 16'h0}, 24, got);
    check(got[15:0] == 16'h0, "R7 read of cleared register", {8'h0, got[15:0]}, 24'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule